// File: doc/BRIEF.md
# Slow-Peripheral Cycle Bridge with Divided Enable Clock

This block lets a fast 68000-class processor reach synchronous peripherals that expect a slow enable clock. It divides a 7 MHz reference into an enable clock whose rising edge lines up with a rising edge of the reference. It qualifies each peripheral access with an active-low valid-memory-address strobe. It then closes the processor's bus cycle by pulsing an active-low data-acknowledge that is registered on the 14 MHz processor clock. The processor's own internal enable-clock handshake is not used: the external logic decides when the peripheral cycle ends.

The termination is a short pipeline. A one-shot term fires on the reference clock once the enable clock is high and the strobe is latched. One reference clock later a second one-shot fires. That one drives a one-cycle acknowledge on the fast clock. The acknowledge pin is meant to be tri-stated, so a separate enable output is high only in the cycle in which the acknowledge is driven low. Both clocks are phase-aligned: the 7 MHz reference is the 14 MHz clock divided by two.

Top module: `eclk_bridge`

## Requirements
- R1: While `rst_n` is low, `e_clk` is 0, `vma_n` is 1, `dtack_n` is 1 and `dtack_oe` is 0.
- R2: `e_clk` repeats every `E_LOW+E_HIGH` cycles of `clk7` (defaults 6 low, 4 high). It changes only on a rising edge of `clk7`.
- R3: `vma_n` goes low at a `clk7` rising edge only if, at that edge, `e_clk` is 0, `vpa_n` is 0 and `as_n` is 0. A select that arrives while `e_clk` is high is not honoured until `e_clk` has fallen.
- R4: Once `vma_n` is low, it stays low for as long as `e_clk` is 1 and `as_n` is 0, even if `vpa_n` returns high.
- R5: When `as_n` is high at a clock edge, `vma_n` is 1 after the next `clk7` edge and `dtack_n` is 1 after the next `clk14` edge. An access dropped before `e_clk` rises gives no acknowledge.
- R6: For a qualified access, `dtack_n` is low for the `clk14` period that starts at the 5th `clk14` rising edge after the `clk7` edge at which `e_clk` rose. That edge is numbered 0. So `dtack_n` only falls while `e_clk` is high.
- R7: Each qualified access that releases `as_n` once acknowledged gives exactly one `dtack_n` low pulse of one `clk14` period. `dtack_oe` is 1 exactly when `dtack_n` is 0.
- R8: With `as_n` low and `vpa_n` high, `vma_n` and `dtack_n` stay 1 and `dtack_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk14 | input | 1 | Processor clock, 14 MHz |
| clk7 | input | 1 | Reference clock, clk14/2, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Processor address strobe, active low |
| vpa_n | input | 1 | Slow-peripheral select, active low |
| e_clk | output | 1 | Divided enable clock |
| vma_n | output | 1 | Valid-memory-address strobe, active low |
| dtack_n | output | 1 | Data-acknowledge level, active low |
| dtack_oe | output | 1 | Output enable for the acknowledge pin |

## Verification
The hardest case to reach is a select that arrives while the enable clock is already high. In that case the strobe must wait a full low phase, and the acknowledge must line up with the following rising edge. The bench waits until it sees `e_clk` rise before it asserts the select, then measures where the acknowledge falls relative to the next rise. Two further cases are forced in the same way. In one, the select is dropped right after `e_clk` rises, to show the latched strobe holds. In the other, the address strobe is withdrawn during the low phase, to show the cycle dies quietly.

// File: rtl/eb_pkg.sv
package eb_pkg;
   localparam int EB_E_LOW_DEF  = 6;
   localparam int EB_E_HIGH_DEF = 4;

   // counter width able to hold values 0..n-1
   function automatic int eb_cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/eb_ediv.sv
module eb_ediv
   import eb_pkg::*;
#(
   parameter int E_LOW  = EB_E_LOW_DEF,
   parameter int E_HIGH = EB_E_HIGH_DEF
) (
   input  logic clk7,
   input  logic rst_n,
   output logic e_o
);
   localparam int PERIOD = E_LOW + E_HIGH;
   localparam int CW     = eb_cnt_w(PERIOD);

   generate
      if (E_LOW < 1 || E_HIGH < 1) begin : g_bad_phase
         $error("eb_ediv: both phases need at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt_q, cnt_nxt;
   logic          e_q;

   always_comb begin
      if (cnt_q == CW'(PERIOD - 1)) cnt_nxt = '0;
      else                          cnt_nxt = cnt_q + CW'(1);
   end

   // E is a register on clk7, so its rising edge is tied to a clk7 rising edge
   always_ff @(posedge clk7 or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         e_q   <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         e_q   <= (cnt_nxt >= CW'(E_LOW));
      end
   end

   assign e_o = e_q;

   // run-length observer for the phase check
   logic chk_prev, chk_armed;
   int   chk_run;
   always_ff @(posedge clk7 or negedge rst_n) begin
      if (!rst_n) begin
         chk_prev  <= 1'b0;
         chk_run   <= 1;
         chk_armed <= 1'b0;
      end else begin
         chk_prev <= e_q;
         if (e_q != chk_prev) begin
            chk_run   <= 1;
            chk_armed <= 1'b1;
         end else begin
            chk_run <= chk_run + 1;
         end
      end
   end

   p_phase_len_r2: assert property (@(posedge clk7) disable iff (!rst_n)
      (chk_armed && (e_q != chk_prev)) |-> (chk_run == (chk_prev ? E_HIGH : E_LOW)));
endmodule

// File: rtl/eb_vma.sv
module eb_vma (
   input  logic clk7,
   input  logic rst_n,
   input  logic e_i,
   input  logic as_n,
   input  logic vpa_n,
   output logic vma_n
);
   logic vma_n_q;
   logic take_w, keep_w;

   // take: select seen in the low phase; keep: hold through the high phase
   assign take_w = !e_i && !vpa_n && !as_n;
   assign keep_w = !vma_n_q && e_i && !as_n;

   always_ff @(posedge clk7 or negedge rst_n) begin
      if (!rst_n) vma_n_q <= 1'b1;
      else        vma_n_q <= !(take_w || keep_w);
   end

   assign vma_n = vma_n_q;

   p_take_r3: assert property (@(posedge clk7) disable iff (!rst_n)
      $fell(vma_n_q) |-> $past(!e_i && !vpa_n && !as_n));
   p_hold_r4: assert property (@(posedge clk7) disable iff (!rst_n)
      (!vma_n_q && e_i && !as_n) |=> !vma_n_q);
   p_as_clear_r5: assert property (@(posedge clk7) disable iff (!rst_n)
      as_n |=> vma_n_q);
endmodule

// File: rtl/eb_term.sv
module eb_term (
   input  logic clk7,
   input  logic rst_n,
   input  logic e_i,
   input  logic as_n,
   input  logic vma_n,
   output logic edtack_n
);
   logic eterm_n_q, edtack_n_q;
   logic eterm_set, edtack_set;

   // each stage can only fire from its idle state, so it self-clears next edge
   assign eterm_set  = eterm_n_q  && e_i && !as_n && !vma_n;
   assign edtack_set = edtack_n_q && !as_n && !eterm_n_q;

   always_ff @(posedge clk7 or negedge rst_n) begin
      if (!rst_n) begin
         eterm_n_q  <= 1'b1;
         edtack_n_q <= 1'b1;
      end else begin
         eterm_n_q  <= !eterm_set;
         edtack_n_q <= !edtack_set;
      end
   end

   assign edtack_n = edtack_n_q;

   p_eterm_pulse_r6: assert property (@(posedge clk7) disable iff (!rst_n)
      !eterm_n_q |=> eterm_n_q);
   p_eterm_cause_r6: assert property (@(posedge clk7) disable iff (!rst_n)
      $fell(eterm_n_q) |-> $past(e_i && !vma_n && !as_n));
   p_edtack_pulse_r7: assert property (@(posedge clk7) disable iff (!rst_n)
      !edtack_n_q |=> edtack_n_q);
   p_edtack_cause_r6: assert property (@(posedge clk7) disable iff (!rst_n)
      $fell(edtack_n_q) |-> $past(!eterm_n_q));
endmodule

// File: rtl/eb_ack.sv
module eb_ack (
   input  logic clk14,
   input  logic rst_n,
   input  logic as_n,
   input  logic edtack_n,
   output logic dtack_n,
   output logic dtack_oe
);
   logic dtack_n_q, oe_q;
   logic fire_w;

   assign fire_w = dtack_n_q && !as_n && !edtack_n;

   // the enable is a second register loaded from the same term
   always_ff @(posedge clk14 or negedge rst_n) begin
      if (!rst_n) begin
         dtack_n_q <= 1'b1;
         oe_q      <= 1'b0;
      end else begin
         dtack_n_q <= !fire_w;
         oe_q      <= fire_w;
      end
   end

   assign dtack_n  = dtack_n_q;
   assign dtack_oe = oe_q;

   p_one_clk_r7: assert property (@(posedge clk14) disable iff (!rst_n)
      !dtack_n_q |=> dtack_n_q);
   p_oe_match_r7: assert property (@(posedge clk14) disable iff (!rst_n)
      oe_q == !dtack_n_q);
   p_as_gate_r5: assert property (@(posedge clk14) disable iff (!rst_n)
      as_n |=> dtack_n_q);
   p_from_chain_r6: assert property (@(posedge clk14) disable iff (!rst_n)
      $fell(dtack_n_q) |-> $past(!edtack_n));
endmodule

// File: rtl/eclk_bridge.sv
module eclk_bridge
   import eb_pkg::*;
#(
   parameter int E_LOW  = EB_E_LOW_DEF,
   parameter int E_HIGH = EB_E_HIGH_DEF
) (
   input  logic clk14,
   input  logic clk7,
   input  logic rst_n,
   input  logic as_n,
   input  logic vpa_n,
   output logic e_clk,
   output logic vma_n,
   output logic dtack_n,
   output logic dtack_oe
);
   logic e_w, vma_n_w, edtack_n_w;

   eb_ediv #(.E_LOW(E_LOW), .E_HIGH(E_HIGH)) u_ediv (
      .clk7 (clk7),
      .rst_n(rst_n),
      .e_o  (e_w)
   );

   eb_vma u_vma (
      .clk7 (clk7),
      .rst_n(rst_n),
      .e_i  (e_w),
      .as_n (as_n),
      .vpa_n(vpa_n),
      .vma_n(vma_n_w)
   );

   eb_term u_term (
      .clk7    (clk7),
      .rst_n   (rst_n),
      .e_i     (e_w),
      .as_n    (as_n),
      .vma_n   (vma_n_w),
      .edtack_n(edtack_n_w)
   );

   eb_ack u_ack (
      .clk14   (clk14),
      .rst_n   (rst_n),
      .as_n    (as_n),
      .edtack_n(edtack_n_w),
      .dtack_n (dtack_n),
      .dtack_oe(dtack_oe)
   );

   assign e_clk = e_w;
   assign vma_n = vma_n_w;

   p_ack_in_ehigh_r6: assert property (@(posedge clk14) disable iff (!rst_n)
      $fell(dtack_n) |-> e_w);
endmodule

// File: tb/sim_eclk_bridge.sv
module sim_eclk_bridge;
   logic clk14, clk7, rst_n, as_n, vpa_n;
   logic e_clk, vma_n, dtack_n, dtack_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // results of the last observation window
   int ob_pulses, ob_pos, ob_oe_bad, ob_hold_bad, ob_early;

   eclk_bridge u0 (
      .clk14(clk14), .clk7(clk7), .rst_n(rst_n), .as_n(as_n), .vpa_n(vpa_n),
      .e_clk(e_clk), .vma_n(vma_n), .dtack_n(dtack_n), .dtack_oe(dtack_oe)
   );

   // 250 MHz fast clock; slow clock toggles on every fast rising edge
   initial begin
      clk14 = 0; clk7 = 0;
      forever begin
         #2 clk14 = 1; clk7 = ~clk7;
         #2 clk14 = 0;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_e_fall();
      do @(negedge clk14); while (!e_clk);
      do @(negedge clk14); while (e_clk);
   endtask

   task automatic wait_e_rise();
      do @(negedge clk14); while (e_clk);
      do @(negedge clk14); while (!e_clk);
   endtask

   // watch n fast cycles; release the access when the acknowledge is seen
   task automatic observe(input int n, input bit drop_vpa_at_rise);
      int  since  = -1;
      bit  prev_e = e_clk;
      ob_pulses = 0; ob_pos = -1; ob_oe_bad = 0; ob_hold_bad = 0; ob_early = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk14);
         if (since >= 0)          since++;
         else if (e_clk && !prev_e) begin
            since = 0;
            if (drop_vpa_at_rise) vpa_n = 1;
         end
         prev_e = e_clk;
         if (dtack_oe != !dtack_n) ob_oe_bad++;
         if (e_clk && since < 0 && !vma_n) ob_early++;
         if (e_clk && since >= 0 && !as_n && vma_n) ob_hold_bad++;
         if (!dtack_n) begin
            ob_pulses++;
            if (ob_pos < 0) ob_pos = since;
            as_n = 1; vpa_n = 1;
         end
      end
   endtask

   task automatic t_reset();
      rst_n = 0; as_n = 1; vpa_n = 1;
      repeat (5) @(negedge clk14);
      chk("R1", "e_clk in reset", e_clk, 0);
      chk("R1", "vma_n in reset", vma_n, 1);
      chk("R1", "dtack_n in reset", dtack_n, 1);
      chk("R1", "dtack_oe in reset", dtack_oe, 0);
      rst_n = 1;
   endtask

   task automatic t_eclk();
      int run = 0, hi_bad = 0, lo_bad = 0, align_bad = 0, edges = 0;
      bit prev;
      @(negedge clk14); prev = e_clk;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk14);
         if (e_clk != prev) begin
            if (!clk7) align_bad++;
            if (edges > 0) begin
               if (prev && run != 8)   hi_bad++;
               if (!prev && run != 12) lo_bad++;
            end
            edges++;
            run = 1;
         end else run++;
         prev = e_clk;
      end
      chk("R2", "high phase length errors", hi_bad, 0);
      chk("R2", "low phase length errors", lo_bad, 0);
      chk("R2", "changes off clk7 rise", align_bad, 0);
      chk("R2", "enough edges seen", edges >= 8, 1);
   endtask

   task automatic t_basic(input string tag);
      wait_e_fall();
      as_n = 0; vpa_n = 0;
      observe(60, 0);
      chk("R7", {tag, " pulse count"}, ob_pulses, 1);
      chk("R6", {tag, " ack position"}, ob_pos, 5);
      chk("R7", {tag, " enable mismatches"}, ob_oe_bad, 0);
      chk("R4", {tag, " strobe dropped in high phase"}, ob_hold_bad, 0);
   endtask

   task automatic t_late_select();
      wait_e_rise();
      as_n = 0; vpa_n = 0;
      observe(60, 0);
      chk("R3", "late select strobe in high phase", ob_early, 0);
      chk("R6", "late select ack position", ob_pos, 5);
      chk("R7", "late select pulse count", ob_pulses, 1);
   endtask

   task automatic t_vpa_drop();
      wait_e_fall();
      as_n = 0; vpa_n = 0;
      observe(60, 1);
      chk("R4", "strobe held after select drop", ob_hold_bad, 0);
      chk("R4", "ack after select drop", ob_pulses, 1);
      chk("R6", "ack position after select drop", ob_pos, 5);
   endtask

   task automatic t_no_select();
      int vma_low = 0, ack = 0, oe = 0;
      as_n = 0; vpa_n = 1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk14);
         if (!vma_n) vma_low++;
         if (!dtack_n) ack++;
         if (dtack_oe) oe++;
      end
      as_n = 1;
      chk("R8", "strobe without select", vma_low, 0);
      chk("R8", "ack without select", ack, 0);
      chk("R8", "enable without select", oe, 0);
   endtask

   task automatic t_abort();
      int vma_low = 0, ack = 0;
      wait_e_fall();
      as_n = 0; vpa_n = 0;
      repeat (4) @(negedge clk14);
      chk("R3", "strobe taken in low phase", vma_n, 0);
      as_n = 1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk14);
         if (i >= 1 && !vma_n) vma_low++;
         if (!dtack_n) ack++;
      end
      vpa_n = 1;
      chk("R5", "strobe after strobe release", vma_low, 0);
      chk("R5", "ack after abort", ack, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_eclk();
      t_basic("first");
      t_basic("second");
      t_late_select();
      t_vpa_drop();
      t_no_select();
      t_abort();
      t_basic("after abort");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule